// File: doc/BRIEF.md
# Serial Stream Channel Router

This block moves four subscriber channels (D, C, B1 and B2, one byte each per frame) between parallel holding registers and one or two 2.048 Mbit/s time-division serial streams. Each direction is handled: transmit bytes are placed into timeslots on a control stream and a data stream, and bytes arriving on the two serial inputs are picked out of their timeslots and presented as parallel receive bytes. A frame holds 32 eight-bit slots. Each bit lasts two clocks of the serial clock, and a frame pulse (active low) marks the start of slot 0.

A 3-bit mode input picks the routing. In dual-port routing the control stream carries C and D in slots 0 and 1, and the data stream carries B1 and B2 in slots 2 and 3. In single-port routing all four channels share the data stream in slots 0 to 3, and the control stream is switched off. D-before-C order can be swapped to C-before-D in one mode only. One mode code keeps both serial outputs undriven, so a chain of devices cannot contend on a shared bus while it powers up. Outside their owned slots the output enables are low, and an external pad turns each output into high impedance.

Top module: `serial_chan_router`

## Requirements
- R1: After reset all four receive outputs are zero. Both output enables stay low from reset until the first frame pulse, even though the slot timing already free-runs.
- R2: The first clock of slot 0, most significant bit, is the cycle after the clock edge that samples `frame_n` low. A bit is 2 clocks, a slot is 16 clocks and a frame is 512 clocks. With no new pulse the count wraps after 512 clocks and the slots repeat with unchanged transmit contents.
- R3: Transmit inputs are captured only on the edge that samples the frame pulse. Each byte is sent most significant bit first in the slot its channel owns, each bit held for two clocks. Changing the inputs during a frame has no effect on that frame.
- R4: Mode field: bit 0 = 1 requests single-port routing, bit 1 = 1 requests C before D, bit 2 = 1 selects modem operation. In modes 0 and 4 the control stream carries D in slot 0 and C in slot 1, and the data stream carries B1 in slot 2 and B2 in slot 3.
- R5: In single-port modes 1 and 3 the data stream carries slots 0, 1, 2 and 3 as first channel, second channel, B1 and B2. The control enable never rises, and the control serial input is ignored.
- R6: C before D (C in slot 0, D in slot 1) applies only in mode 2. Bit 1 is ignored in modes 3 and 6, which send D first.
- R7: When bit 2 is set, bit 0 is ignored: mode 5 routes exactly like mode 4.
- R8: Mode 7 holds both output enables low for the whole frame. Its receive routing is that of mode 0.
- R9: Each output enable is high for exactly the 16 clocks of every slot that its stream owns, and low in all other slots.
- R10: Each serial input is sampled on the second clock of every bit of an owned slot, most significant bit first. All four receive outputs change together on the next frame-pulse edge, taking the bytes completed before that edge, and hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock, two clocks per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame pulse, one clock wide |
| mode | input | 3 | Routing mode code (see R4) |
| tx_dch | input | 8 | D channel byte to send |
| tx_cch | input | 8 | C channel byte to send |
| tx_b1 | input | 8 | B1 channel byte to send |
| tx_b2 | input | 8 | B2 channel byte to send |
| rx_dch | output | 8 | Received D channel byte |
| rx_cch | output | 8 | Received C channel byte |
| rx_b1 | output | 8 | Received B1 channel byte |
| rx_b2 | output | 8 | Received B2 channel byte |
| data_sin | input | 1 | Data stream serial input |
| ctrl_sin | input | 1 | Control stream serial input |
| data_sout | output | 1 | Data stream serial output |
| data_soe | output | 1 | Data stream output enable |
| ctrl_sout | output | 1 | Control stream serial output |
| ctrl_soe | output | 1 | Control stream output enable |

## Verification
Every frame-pulse edge does two things at once: it latches the new transmit bytes and it publishes the receive bytes gathered in the frame that just ended. The bench therefore sets fresh transmit inputs in the very cycle of each pulse and scrambles them a few clocks later. The slots of the new frame must carry the values present at the pulse, while the receive outputs seen in the first clock must show the bytes of the previous frame under that frame's mode. One frame has no pulse at all, which shows that neither action happens on a plain wrap of the count.

// File: rtl/ssr_pkg.sv
// Shared types for the serial stream channel router.
// Assumes four channels, indexed D=0, C=1, B1=2, B2=3.
package ssr_pkg;

    typedef enum logic [1:0] {
        CH_D  = 2'd0,
        CH_C  = 2'd1,
        CH_B1 = 2'd2,
        CH_B2 = 2'd3
    } chan_e;

    typedef struct packed {
        logic single;   // all channels on the data stream
        logic c_first;  // C precedes D on the control stream
        logic silent;   // both output enables forced low
    } route_t;

    typedef struct packed {
        logic  used;
        chan_e ch;
    } owner_t;

    localparam logic [2:0] MODE_SILENT = 3'd7;

    // Turn the 3-bit mode code into routing flags, applying the restrictions.
    function automatic route_t decode_mode(input logic [2:0] mode);
        route_t r;
        r.silent  = (mode == MODE_SILENT);
        r.single  = mode[0] & ~mode[2];
        r.c_first = mode[1] & ~mode[0] & ~mode[2];
        return r;
    endfunction

    // Which channel, if any, owns a slot of the given stream.
    function automatic owner_t slot_owner(input route_t r, input logic data_stream,
                                          input int unsigned slot);
        owner_t o;
        chan_e  first;
        chan_e  second;
        first  = r.c_first ? CH_C : CH_D;
        second = r.c_first ? CH_D : CH_C;
        o.used = 1'b0;
        o.ch   = CH_D;
        if (data_stream) begin
            if (r.single && slot == 0) begin
                o.used = 1'b1; o.ch = first;
            end else if (r.single && slot == 1) begin
                o.used = 1'b1; o.ch = second;
            end else if (slot == 2) begin
                o.used = 1'b1; o.ch = CH_B1;
            end else if (slot == 3) begin
                o.used = 1'b1; o.ch = CH_B2;
            end
        end else if (!r.single) begin
            if (slot == 0) begin
                o.used = 1'b1; o.ch = first;
            end else if (slot == 1) begin
                o.used = 1'b1; o.ch = second;
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/ssr_timebase.sv
// Frame timebase: cascaded phase, bit and slot counters restarted by the
// active-low frame pulse and free-running otherwise.
// Assumes frame_n is synchronous to clk and one clock wide.
module ssr_timebase #(
    parameter int SLOTS        = 32,
    parameter int SLOT_BITS    = 8,
    parameter int CLKS_PER_BIT = 2,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BIT_W  = $clog2(SLOT_BITS),
    localparam int PH_W   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    output logic              synced,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              sample_now,
    output logic              slot_end
);
    localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(CLKS_PER_BIT - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [PH_W-1:0] phase;

    // Advance the position counters; a frame pulse restarts them at slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            bit_idx  <= '0;
            slot_idx <= '0;
            synced   <= 1'b0;
        end else if (!frame_n) begin
            phase    <= '0;
            bit_idx  <= '0;
            slot_idx <= '0;
            synced   <= 1'b1;
        end else if (phase == LAST_PH) begin
            phase <= '0;
            if (bit_idx == LAST_BIT) begin
                bit_idx  <= '0;
                slot_idx <= (slot_idx == LAST_SLOT) ? '0 : slot_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Sample strobe on the last clock of each bit, once aligned.
    always_comb begin
        sample_now = synced && (phase == LAST_PH);
        slot_end   = sample_now && (bit_idx == LAST_BIT);
    end

    a_r2_pulse_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> (slot_idx == '0 && bit_idx == '0 && phase == '0));

    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && slot_idx == LAST_SLOT && bit_idx == LAST_BIT && phase == LAST_PH)
        |=> (slot_idx == '0 && bit_idx == '0));

endmodule

// File: rtl/ssr_lane.sv
// One serial stream lane: drives the owned slot bits from the transmit
// holding bytes and assembles received bytes for the owning channel.
// Assumes SLOT_BITS >= 3 and routing held steady within a slot.
module ssr_lane
    import ssr_pkg::*;
#(
    parameter int   SLOT_BITS = 8,
    parameter int   SLOT_W    = 5,
    parameter int   BIT_W     = 3,
    parameter logic IS_DATA   = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  route_t                     route,
    input  logic                       synced,
    input  logic [SLOT_W-1:0]          slot_idx,
    input  logic [BIT_W-1:0]           bit_idx,
    input  logic                       sample_now,
    input  logic                       slot_end,
    input  logic [3:0][SLOT_BITS-1:0]  tx_bytes,
    input  logic                       ser_in,
    output logic                       ser_out,
    output logic                       ser_oe,
    output logic                       rx_wr,
    output chan_e                      rx_ch,
    output logic [SLOT_BITS-1:0]       rx_byte
);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(SLOT_BITS - 1);

    owner_t               owner;
    logic [SLOT_BITS-1:0] cur_byte;
    logic [SLOT_BITS-2:0] shreg;

    // Select the owner of the current slot and the bit to send.
    always_comb begin
        owner    = slot_owner(route, IS_DATA, 32'(slot_idx));
        cur_byte = tx_bytes[owner.ch];
        ser_oe   = synced && owner.used && !route.silent;
        ser_out  = ser_oe ? cur_byte[TOP_BIT - bit_idx] : 1'b1;
        rx_byte  = {shreg, ser_in};
        rx_wr    = slot_end && owner.used;
        rx_ch    = owner.ch;
    end

    // Shift in received bits of owned slots, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sample_now && owner.used) begin
            shreg <= {shreg[SLOT_BITS-3:0], ser_in};
        end
    end

    a_r9_enable_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe |-> (32'(slot_idx) < 4));

endmodule

// File: rtl/serial_chan_router.sv
// Serial stream channel router top: maps D, C, B1 and B2 onto a control and
// a data time-division stream in both directions according to the mode.
// Assumes frame_n arrives once per frame and mode changes only near a pulse.
module serial_chan_router
    import ssr_pkg::*;
#(
    parameter int SLOTS        = 32,
    parameter int SLOT_BITS    = 8,
    parameter int CLKS_PER_BIT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n,
    input  logic [2:0]           mode,
    input  logic [SLOT_BITS-1:0] tx_dch,
    input  logic [SLOT_BITS-1:0] tx_cch,
    input  logic [SLOT_BITS-1:0] tx_b1,
    input  logic [SLOT_BITS-1:0] tx_b2,
    output logic [SLOT_BITS-1:0] rx_dch,
    output logic [SLOT_BITS-1:0] rx_cch,
    output logic [SLOT_BITS-1:0] rx_b1,
    output logic [SLOT_BITS-1:0] rx_b2,
    input  logic                 data_sin,
    input  logic                 ctrl_sin,
    output logic                 data_sout,
    output logic                 data_soe,
    output logic                 ctrl_sout,
    output logic                 ctrl_soe
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(SLOT_BITS);
    localparam int LANES  = 2;   // 0 = control stream, 1 = data stream

    logic                       synced;
    logic [SLOT_W-1:0]          slot_idx;
    logic [BIT_W-1:0]           bit_idx;
    logic                       sample_now;
    logic                       slot_end;
    route_t                     route;
    logic [3:0][SLOT_BITS-1:0]  tx_hold;
    logic [3:0][SLOT_BITS-1:0]  staging;
    logic [3:0][SLOT_BITS-1:0]  rx_hold;

    logic [LANES-1:0]           lane_in;
    logic [LANES-1:0]           lane_out;
    logic [LANES-1:0]           lane_oe;
    logic [LANES-1:0]           lane_wr;
    chan_e                      lane_ch   [LANES];
    logic [SLOT_BITS-1:0]       lane_byte [LANES];

    ssr_timebase #(
        .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .CLKS_PER_BIT(CLKS_PER_BIT)
    ) i_timebase (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .synced(synced),
        .slot_idx(slot_idx), .bit_idx(bit_idx),
        .sample_now(sample_now), .slot_end(slot_end)
    );

    // Decode the routing and map lanes onto the serial pins.
    always_comb begin
        route      = decode_mode(mode);
        lane_in    = {data_sin, ctrl_sin};
        ctrl_sout  = lane_out[0];
        ctrl_soe   = lane_oe[0];
        data_sout  = lane_out[1];
        data_soe   = lane_oe[1];
        rx_dch     = rx_hold[CH_D];
        rx_cch     = rx_hold[CH_C];
        rx_b1      = rx_hold[CH_B1];
        rx_b2      = rx_hold[CH_B2];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ssr_lane #(
            .SLOT_BITS(SLOT_BITS), .SLOT_W(SLOT_W), .BIT_W(BIT_W),
            .IS_DATA(l == 1)
        ) i_lane (
            .clk(clk), .rst_n(rst_n), .route(route), .synced(synced),
            .slot_idx(slot_idx), .bit_idx(bit_idx),
            .sample_now(sample_now), .slot_end(slot_end),
            .tx_bytes(tx_hold), .ser_in(lane_in[l]),
            .ser_out(lane_out[l]), .ser_oe(lane_oe[l]),
            .rx_wr(lane_wr[l]), .rx_ch(lane_ch[l]), .rx_byte(lane_byte[l])
        );
    end

    // Latch transmit bytes and publish received bytes on each frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            rx_hold <= '0;
        end else if (!frame_n) begin
            tx_hold <= {tx_b2, tx_b1, tx_cch, tx_dch};
            rx_hold <= staging;
        end
    end

    // Store each completed received byte under its owning channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staging <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_wr[l]) staging[lane_ch[l]] <= lane_byte[l];
            end
        end
    end

    a_r1_quiet_until_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> (!data_soe && !ctrl_soe));

    a_r8_silent_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd7) |-> (!data_soe && !ctrl_soe));

    a_r5_single_ctrl_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 || mode == 3'd3) |-> !ctrl_soe);

    a_r9_late_slots_off: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(slot_idx) >= 4) |-> (!data_soe && !ctrl_soe));

    a_r3_tx_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |=> $stable(tx_hold));

    a_r10_rx_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |=> $stable(rx_hold));

endmodule

// File: tb/test_serial_chan_router.sv
// Scoreboard bench: a driver task queues the expected slot contents and
// receive bytes per frame; a monitor process pops and compares them.
`timescale 1ns/1ps
module test_serial_chan_router;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic [2:0] mode = 3'd0;
    logic [7:0] tx_dch = '0, tx_cch = '0, tx_b1 = '0, tx_b2 = '0;
    logic [7:0] rx_dch, rx_cch, rx_b1, rx_b2;
    logic       data_sin = 1'b1, ctrl_sin = 1'b1;
    logic       data_sout, data_soe, ctrl_sout, ctrl_soe;

    serial_chan_router i_serial_chan_router (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .mode(mode),
        .tx_dch(tx_dch), .tx_cch(tx_cch), .tx_b1(tx_b1), .tx_b2(tx_b2),
        .rx_dch(rx_dch), .rx_cch(rx_cch), .rx_b1(rx_b1), .rx_b2(rx_b2),
        .data_sin(data_sin), .ctrl_sin(ctrl_sin),
        .data_sout(data_sout), .data_soe(data_soe),
        .ctrl_sout(ctrl_sout), .ctrl_soe(ctrl_soe)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int  checks = 0;
    int  fails  = 0;
    int  bpos   = -1;
    bit  done   = 1'b0;

    bit         oe_q[$];
    logic [7:0] val_q[$];
    string      tag_q[$];
    logic [31:0] rx_q[$];
    string      rxtag_q[$];

    logic [7:0]  tx_model [4];
    logic [31:0] prev_rx = '0;
    logic [31:0] pub_rx  = '0;
    string       prev_tag = "R10 R1";

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected channel owning a slot (-1 = none), taken from R4 to R8.
    function automatic int owner_of(input logic [2:0] m, input int s,
                                    input int slot, input bit for_rx);
        bit single;
        int first;
        int second;
        single = (m == 3'd1) || (m == 3'd3);
        first  = (m == 3'd2) ? 1 : 0;
        second = (m == 3'd2) ? 0 : 1;
        if (m == 3'd7 && !for_rx) return -1;
        if (s == 1) begin
            if (single && slot == 0) return first;
            if (single && slot == 1) return second;
            if (slot == 2 || slot == 3) return slot;
        end else if (!single && slot < 2) begin
            return (slot == 0) ? first : second;
        end
        return -1;
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R5 R6";
            3'd5:    return "R7";
            3'd6:    return "R6";
            3'd7:    return "R8";
            default: return "R4";
        endcase
    endfunction

    // Driver: one frame, optionally started by a pulse, with queued expectations.
    task automatic run_frame(input logic [2:0] m, input bit pulse, input int k);
        logic [7:0] txv [4];
        logic [7:0] dvr [4];
        logic [7:0] cdr [4];
        string      tag;
        int         ch;
        for (int j = 0; j < 4; j++) begin
            txv[j] = 8'(k * 37 + j * 91 + 5);
            dvr[j] = 8'(k * 53 + j * 29 + 140);
            cdr[j] = 8'(k * 71 + j * 17 + 66);
        end
        if (pulse) begin
            mode = m;
            {tx_b2, tx_b1, tx_cch, tx_dch} = {txv[3], txv[2], txv[1], txv[0]};
            for (int j = 0; j < 4; j++) tx_model[j] = txv[j];
            frame_n = 1'b0;
            pub_rx  = prev_rx;
            tag = mode_tag(m);
        end else begin
            tag = "R2 R3";
        end
        rx_q.push_back(pub_rx);
        rxtag_q.push_back(pulse ? prev_tag : "R10 R2");
        for (int s = 0; s < 2; s++) begin
            for (int sl = 0; sl < 4; sl++) begin
                ch = owner_of(mode, s, sl, 1'b0);
                oe_q.push_back(ch >= 0);
                val_q.push_back(ch >= 0 ? tx_model[ch] : 8'h00);
                tag_q.push_back(tag);
            end
        end
        for (int p = 0; p < 512; p++) begin
            @(posedge clk);
            @(negedge clk);
            bpos    = p;
            frame_n = 1'b1;
            if (p == 5) {tx_b2, tx_b1, tx_cch, tx_dch} = ~{txv[3], txv[2], txv[1], txv[0]};
            if (p / 16 < 4) begin
                data_sin = dvr[p / 16][7 - (p / 2) % 8];
                ctrl_sin = cdr[p / 16][7 - (p / 2) % 8];
            end else begin
                data_sin = 1'((p >> 2) & 1);
                ctrl_sin = 1'((p >> 3) & 1);
            end
        end
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int sl = 0; sl < 4; sl++) begin
                    if (owner_of(mode, s, sl, 1'b1) == c)
                        prev_rx[c * 8 +: 8] = (s == 1) ? dvr[sl] : cdr[sl];
                end
            end
        end
        prev_tag = (mode == 3'd7) ? "R10 R8" :
                   ((mode == 3'd1 || mode == 3'd3) ? "R10 R5" : "R10");
    endtask

    // Monitor state.
    bit         have_cur = 1'b0;
    bit         cur_oe  [2][4];
    logic [7:0] cur_val [2][4];
    string      cur_tag [2][4];
    logic [7:0] acc     [2][4];
    bit         bad     [2][4];
    bit         stray   [2];
    logic [31:0] rx_exp;
    string       rx_tag;
    int          msl;
    int          mbt;
    logic        m_oe;
    logic        m_out;

    // Monitor: pop expectations at slot 0 and compare slots as they finish.
    always @(negedge clk) begin
        #1;
        if (bpos >= 0) begin
            if (bpos == 0) begin
                if (rx_q.size() > 0) begin
                    rx_exp = rx_q.pop_front();
                    rx_tag = rxtag_q.pop_front();
                    check({rx_b2, rx_b1, rx_cch, rx_dch} == rx_exp, rx_tag,
                          "published receive bytes", {rx_b2, rx_b1, rx_cch, rx_dch}, rx_exp);
                end
                have_cur = (oe_q.size() >= 8);
                if (have_cur) begin
                    for (int s = 0; s < 2; s++) begin
                        stray[s] = 1'b0;
                        for (int sl = 0; sl < 4; sl++) begin
                            cur_oe[s][sl]  = oe_q.pop_front();
                            cur_val[s][sl] = val_q.pop_front();
                            cur_tag[s][sl] = tag_q.pop_front();
                            acc[s][sl] = '0;
                            bad[s][sl] = 1'b0;
                        end
                    end
                end
            end
            if (have_cur) begin
                msl = bpos / 16;
                mbt = (bpos / 2) % 8;
                for (int s = 0; s < 2; s++) begin
                    m_oe  = (s == 1) ? data_soe : ctrl_soe;
                    m_out = (s == 1) ? data_sout : ctrl_sout;
                    if (msl < 4) begin
                        if (m_oe !== cur_oe[s][msl]) bad[s][msl] = 1'b1;
                        if (bpos % 2 == 0) acc[s][msl][7 - mbt] = m_out;
                        if (bpos % 16 == 15) begin
                            if (bad[s][msl])
                                check(1'b0, {"R9 ", cur_tag[s][msl]}, "enable window",
                                      32'(m_oe), 32'(cur_oe[s][msl]));
                            else if (cur_oe[s][msl])
                                check(acc[s][msl] === cur_val[s][msl],
                                      {"R3 ", cur_tag[s][msl]}, "slot byte",
                                      32'(acc[s][msl]), 32'(cur_val[s][msl]));
                            else
                                check(1'b1, {"R9 ", cur_tag[s][msl]}, "unowned slot", 0, 0);
                        end
                    end else if (m_oe !== 1'b0) begin
                        stray[s] = 1'b1;
                    end
                    if (bpos == 511)
                        check(!stray[s], "R9", "enable outside slots 0 to 3",
                              32'(stray[s]), 0);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(200000 * CLK_NS);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    bit ok_reset;
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        ok_reset = 1'b1;
        // R1: nothing driven and receive bytes zero before the first pulse.
        repeat (600) begin
            @(negedge clk);
            #1;
            if (data_soe !== 1'b0 || ctrl_soe !== 1'b0 ||
                {rx_b2, rx_b1, rx_cch, rx_dch} !== 32'h0) ok_reset = 1'b0;
        end
        check(ok_reset, "R1", "state before first pulse",
              {rx_b2, rx_b1, rx_cch, rx_dch}, 32'h0);
        for (int m = 0; m < 8; m++) run_frame(3'(m), 1'b1, m);
        run_frame(3'd2, 1'b1, 8);
        run_frame(3'd2, 1'b0, 9);
        run_frame(3'd0, 1'b1, 10);
        // Final pulse publishes the last frame's receive bytes.
        pub_rx = prev_rx;
        rx_q.push_back(pub_rx);
        rxtag_q.push_back(prev_tag);
        frame_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        bpos    = 0;
        frame_n = 1'b1;
        #3;
        bpos = -1;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule